// File: doc/BRIEF.md
# Receive DMA Channel with Selectable Interrupt Behaviour

This block is one receive channel of a DMA engine. Bytes from a serial receiver are accepted while the channel runs and staged in a four-entry FIFO. From there they are written one at a time into a circular buffer in memory through a simple write port that has a request and ready pair. The memory address is an 8-bit segment placed above a 16-bit address pointer. The pointer advances after each completed write. After it writes at the bound address, it wraps back to the base address. Software sets up the channel and watches it through a small register port. Register writes take effect at the clock edge. A read returns its data one cycle after the address is presented.

The channel raises an interrupt in one of three ways, chosen by a mode field. In periodic mode, a working counter is loaded whenever software writes the byte-count register. Each accepted byte decrements it. The byte that finds the counter at one (or zero) raises the flag and reloads the counter by hardware. In timeout mode, a timer restarts on every accepted byte. The flag rises when the programmed number of cycles passes with no new byte. In silent mode, data still streams into memory but the flag is never raised. The flag is sticky and is cleared by writing one to it. The output bit that goes to the shared interrupt register is the flag gated by the enable bit.

Top module: `rxdma_chan`

## Requirements
- R1: After reset, every register reads as zero, the memory request is low and the interrupt output is low.
- R2: Register addresses are 0 control, 1 status, 2 segment, 3 base, 4 bound, 5 pointer, 6 byte count, 7 timeout. A write loads the addressed register at the clock edge. The read data one cycle after an address is presented holds that register's value before that edge. The segment keeps bits [7:0], and unused bits read as zero.
- R3: Control bit 0 is run. While it is 0, incoming bytes are not accepted: the FIFO level, the pointer and the memory request do not change because of them.
- R4: Accepted bytes leave the four-deep FIFO in arrival order. While the FIFO is not empty, mem_req is high, mem_wdata is the oldest byte and mem_addr is {segment, pointer}. A write completes in a cycle when mem_ready is high.
- R5: Each completed write advances the pointer by one. A write at the bound address reloads the pointer with the base. A software write to the pointer takes priority.
- R6: A byte that arrives while running with four bytes held is dropped, and it sets status bit 1 (overrun). Status bits [4:2] show the FIFO level. Writing 1 to status bit 1 clears the overrun bit.
- R7: Mode is control bits [2:1]. With value 1 (periodic), one interrupt is raised for every n accepted bytes, where n is the byte-count value. The working counter is loaded when the byte-count register is written and is reloaded by hardware after each interrupt.
- R8: With mode value 2 (timeout), the flag is set when the timeout value's number of cycles passes after an accepted byte with no further byte. No further timeout fires until another byte is accepted.
- R9: With mode value 0 (silent), bytes are still written to memory, but the flag is never set.
- R10: Status bit 0 is the sticky interrupt flag, cleared by writing 1 to it. irq_o equals the flag ANDed with control bit 3 (enable), and it is updated at the same edge as the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| mem_req | output | 1 | A byte is waiting to be written |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| mem_addr | output | 24 | Write address, segment over pointer |
| mem_wdata | output | 8 | Byte to write |
| irq_o | output | 1 | Enabled interrupt flag toward the shared register |

## Verification
The embedded properties assume that the receiver gives at most one byte per cycle. They assume that mem_ready is looked at only while mem_req is high. They also assume that the configured bound is reached by counting up from the base, so that the wrap check is meaningful. The stimulus keeps rx_valid a single-cycle strobe and sets up the buffer window before the run bit is set. In its random phase it rewrites only the control, status, byte-count and timeout registers, using small counts and timeouts, so that every mode change and every interrupt is seen many times. A behavioural model compares every output on every cycle across mode switches, flag clears and stalls of the memory port.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [1:0] {
    MODE_SILENT   = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_TIMEOUT  = 2'd2,
    MODE_SPARE    = 2'd3
  } rx_mode_e;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_SEG   = 3'd2;
  localparam logic [2:0] RA_BASE  = 3'd3;
  localparam logic [2:0] RA_BOUND = 3'd4;
  localparam logic [2:0] RA_PTR   = 3'd5;
  localparam logic [2:0] RA_COUNT = 3'd6;
  localparam logic [2:0] RA_TMO   = 3'd7;
endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  logic [W-1:0]     store [DEPTH];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;

  // storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + IDX_W'(1);
      if (pop)  rd_q <= rd_q + IDX_W'(1);
      case ({push, pop})
        2'b10:   lvl_q <= lvl_q + LVL_W'(1);
        2'b01:   lvl_q <= lvl_q - LVL_W'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign dout  = store[rd_q];
  assign level = lvl_q;
  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LVL_W'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_level_up_R4: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> level == $past(level) + LVL_W'(1));
endmodule

// File: rtl/rxdma_evt.sv
module rxdma_evt
  import rxdma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  rx_mode_e         mode,
  input  logic             acc,
  input  logic             ld_cnt,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload,
  input  logic [TMO_W-1:0] tmo,
  output logic             fire
);
  logic [CNT_W-1:0] work_q;
  logic [TMO_W-1:0] tmr_q;
  logic             armed_q;
  logic [TMO_W:0]   tmr_inc;
  logic             per_on, tmo_on, fire_per, fire_tmo, expired;

  assign per_on   = (mode == MODE_PERIODIC);
  assign tmo_on   = run && (mode == MODE_TIMEOUT);
  assign tmr_inc  = {1'b0, tmr_q} + (TMO_W + 1)'(1);
  assign expired  = (tmr_inc >= {1'b0, tmo});
  assign fire_per = acc && per_on && (work_q <= CNT_W'(1));
  assign fire_tmo = tmo_on && armed_q && !acc && expired;
  assign fire     = fire_per || fire_tmo;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
    end else if (ld_cnt) begin
      work_q <= ld_val;
    end else if (acc && per_on) begin
      work_q <= (work_q <= CNT_W'(1)) ? reload : work_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !tmo_on) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else if (acc) begin
      armed_q <= 1'b1;
      tmr_q   <= '0;
    end else if (armed_q) begin
      if (expired) armed_q <= 1'b0;
      else         tmr_q   <= tmr_inc[TMO_W-1:0];
    end
  end

  assert_count_down_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && per_on && !ld_cnt && work_q > CNT_W'(1)) |=> work_q == $past(work_q) - CNT_W'(1));
  assert_one_shot_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == MODE_TIMEOUT) |=> !armed_q);
endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan
  import rxdma_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 16,
  parameter int SEG_W  = 8,
  parameter int CNT_W  = 16,
  parameter int TMO_W  = 16,
  parameter int REG_W  = 16,
  parameter int RA_W   = 3,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int MA_W  = SEG_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic [MA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq_o
);
  logic             run_q, ien_q, flag_q, ovr_q;
  rx_mode_e         mode_q;
  logic [SEG_W-1:0] seg_q;
  logic [PTR_W-1:0] base_q, bound_q, ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TMO_W-1:0] tmo_q;

  logic             wr_ctrl, wr_stat, wr_seg, wr_base, wr_bound, wr_ptr, wr_cnt, wr_tmo;
  logic             acc, drop, wdone, fire, empty, full, flag_d, ien_d;
  logic [LVL_W-1:0] level;
  logic [REG_W-1:0] rd_v, stat_v;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == RA_STAT);
  assign wr_seg   = reg_wr && (reg_addr == RA_SEG);
  assign wr_base  = reg_wr && (reg_addr == RA_BASE);
  assign wr_bound = reg_wr && (reg_addr == RA_BOUND);
  assign wr_ptr   = reg_wr && (reg_addr == RA_PTR);
  assign wr_cnt   = reg_wr && (reg_addr == RA_COUNT);
  assign wr_tmo   = reg_wr && (reg_addr == RA_TMO);

  assign acc     = rx_valid && run_q && !full;
  assign drop    = rx_valid && run_q && full;
  assign mem_req = !empty;
  assign wdone   = mem_req && mem_ready;

  rxdma_fifo #(.W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(acc), .din(rx_data), .pop(wdone),
    .dout(mem_wdata), .level(level), .empty(empty), .full(full)
  );

  rxdma_evt #(.CNT_W(CNT_W), .TMO_W(TMO_W)) evt_i (
    .clk(clk), .rst(rst), .run(run_q), .mode(mode_q), .acc(acc),
    .ld_cnt(wr_cnt), .ld_val(reg_wdata[CNT_W-1:0]), .reload(cnt_q),
    .tmo(tmo_q), .fire(fire)
  );

  assign flag_d   = (flag_q && !(wr_stat && reg_wdata[0])) || fire;
  assign ien_d    = wr_ctrl ? reg_wdata[3] : ien_q;
  assign mem_addr = {seg_q, ptr_q};

  always_comb begin
    stat_v = '0;
    stat_v[0] = flag_q;
    stat_v[1] = ovr_q;
    stat_v[LVL_W+1:2] = level;
    case (reg_addr)
      RA_CTRL:  rd_v = REG_W'({ien_q, mode_q, run_q});
      RA_STAT:  rd_v = stat_v;
      RA_SEG:   rd_v = REG_W'(seg_q);
      RA_BASE:  rd_v = REG_W'(base_q);
      RA_BOUND: rd_v = REG_W'(bound_q);
      RA_PTR:   rd_v = REG_W'(ptr_q);
      RA_COUNT: rd_v = REG_W'(cnt_q);
      default:  rd_v = REG_W'(tmo_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; ien_q <= 1'b0; mode_q <= MODE_SILENT;
      flag_q <= 1'b0; ovr_q <= 1'b0; irq_o <= 1'b0;
      seg_q <= '0; base_q <= '0; bound_q <= '0; ptr_q <= '0;
      cnt_q <= '0; tmo_q <= '0; reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_v;
      flag_q    <= flag_d;
      ien_q     <= ien_d;
      irq_o     <= flag_d && ien_d;
      ovr_q     <= (ovr_q && !(wr_stat && reg_wdata[1])) || drop;
      if (wr_ctrl) begin
        run_q  <= reg_wdata[0];
        mode_q <= rx_mode_e'(reg_wdata[2:1]);
      end
      if (wr_seg)   seg_q   <= reg_wdata[SEG_W-1:0];
      if (wr_base)  base_q  <= reg_wdata[PTR_W-1:0];
      if (wr_bound) bound_q <= reg_wdata[PTR_W-1:0];
      if (wr_cnt)   cnt_q   <= reg_wdata[CNT_W-1:0];
      if (wr_tmo)   tmo_q   <= reg_wdata[TMO_W-1:0];
      if (wr_ptr)     ptr_q <= reg_wdata[PTR_W-1:0];
      else if (wdone) ptr_q <= (ptr_q == bound_q) ? base_q : ptr_q + PTR_W'(1);
    end
  end

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (wdone && ptr_q == bound_q && !wr_ptr) |=> ptr_q == $past(base_q));
  assert_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SILENT && !flag_q) |=> !flag_q);
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ien_q);
  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wdone) |=> level == $past(level));
endmodule

// File: tb/rxdma_chan_tb_top.sv
module rxdma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_req, mem_ready = 1'b1;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rxdma_chan dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_o(irq_o)
  );

  // behavioural reference model
  logic        m_run, m_ien, m_flag, m_ovr, m_irq, m_armed;
  logic [1:0]  m_mode;
  logic [7:0]  m_seg;
  logic [15:0] m_base, m_bound, m_ptr, m_cnt, m_tmo, m_rd;
  int          m_work, m_tmr;
  logic [7:0]  m_q[$];

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {12'd0, m_ien, m_mode, m_run};
      3'd1: return {11'd0, 3'(m_q.size()), m_ovr, m_flag};
      3'd2: return {8'd0, m_seg};
      3'd3: return m_base;
      3'd4: return m_bound;
      3'd5: return m_ptr;
      3'd6: return m_cnt;
      default: return m_tmo;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_ien = 0; m_flag = 0; m_ovr = 0; m_irq = 0; m_armed = 0;
      m_mode = 0; m_seg = 0; m_base = 0; m_bound = 0; m_ptr = 0;
      m_cnt = 0; m_tmo = 0; m_rd = 0; m_work = 0; m_tmr = 0;
      m_q.delete();
    end else begin
      bit acc, drop, wdone, fp, ft, wr;
      acc   = rx_valid && m_run && m_q.size() < 4;
      drop  = rx_valid && m_run && m_q.size() == 4;
      wdone = m_q.size() > 0 && mem_ready;
      fp    = acc && m_mode == 2'd1 && m_work <= 1;
      ft    = m_run && m_mode == 2'd2 && m_armed && !acc && (m_tmr + 1 >= int'(m_tmo));
      m_rd  = model_read(reg_addr);
      wr    = reg_wr;
      if (m_run && m_mode == 2'd2) begin
        if (acc) begin m_armed = 1; m_tmr = 0; end
        else if (m_armed) begin
          if (m_tmr + 1 >= int'(m_tmo)) m_armed = 0; else m_tmr = m_tmr + 1;
        end
      end else begin m_armed = 0; m_tmr = 0; end
      if (wr && reg_addr == 3'd6) m_work = int'(reg_wdata);
      else if (acc && m_mode == 2'd1) m_work = (m_work <= 1) ? int'(m_cnt) : m_work - 1;
      m_flag = (m_flag && !(wr && reg_addr == 3'd1 && reg_wdata[0])) || fp || ft;
      m_ovr  = (m_ovr && !(wr && reg_addr == 3'd1 && reg_wdata[1])) || drop;
      if (wdone) void'(m_q.pop_front());
      if (acc) m_q.push_back(rx_data);
      if (wr && reg_addr == 3'd5) m_ptr = reg_wdata;
      else if (wdone) m_ptr = (m_ptr == m_bound) ? m_base : m_ptr + 16'd1;
      if (wr) case (reg_addr)
        3'd0: begin m_run = reg_wdata[0]; m_mode = reg_wdata[2:1]; m_ien = reg_wdata[3]; end
        3'd2: m_seg = reg_wdata[7:0];
        3'd3: m_base = reg_wdata;
        3'd4: m_bound = reg_wdata;
        3'd6: m_cnt = reg_wdata;
        3'd7: m_tmo = reg_wdata;
        default: ;
      endcase
      m_irq = m_flag && m_ien;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(mem_req == (m_q.size() > 0), "R4 mem_req", mem_req, m_q.size() > 0);
      if (m_q.size() > 0) begin
        chk(mem_wdata == m_q[0], "R4 mem_wdata", mem_wdata, m_q[0]);
        chk(mem_addr == {m_seg, m_ptr}, "R5 mem_addr", mem_addr, {m_seg, m_ptr});
      end
      chk(irq_o == m_irq, "R10 irq_o", irq_o, m_irq);
      chk(reg_rdata == m_rd, "R2 reg_rdata", reg_rdata, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(mem_req == 0, "R1 mem_req", mem_req, 0);
    chk(irq_o == 0, "R1 irq_o", irq_o, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    // R2 configuration readback
    wr(3'd2, 16'h1234);
    wr(3'd3, 16'h0100);
    wr(3'd4, 16'h0103);
    wr(3'd5, 16'h0100);
    wr(3'd6, 16'd3);
    rd(3'd2, v); chk(v == 16'h0034, "R2 segment width", v, 16'h0034);
    rd(3'd3, v); chk(v == 16'h0100, "R2 base", v, 16'h0100);
    // R7 periodic mode
    wr(3'd0, 16'h000B);
    send(8'h11); send(8'h12); send(8'h13); idle(2);
    chk(irq_o == 1, "R7 third byte", irq_o, 1);
    wr(3'd1, 16'h0001); idle(1);
    chk(irq_o == 0, "R10 clear", irq_o, 0);
    send(8'h14); idle(3);
    rd(3'd5, v); chk(v == 16'h0100, "R5 wrap to base", v, 16'h0100);
    send(8'h15); idle(2);
    chk(irq_o == 0, "R7 fifth byte", irq_o, 0);
    send(8'h16); idle(2);
    chk(irq_o == 1, "R7 sixth byte", irq_o, 1);
    wr(3'd1, 16'h0001);
    // R6 overrun with stalled memory
    @(negedge clk); mem_ready = 0;
    for (int i = 0; i < 6; i++) begin
      rx_valid = 1; rx_data = 8'hA0 + 8'(i); @(negedge clk);
    end
    rx_valid = 0;
    chk(mem_wdata == 8'hA0, "R4 oldest byte", mem_wdata, 8'hA0);
    chk(mem_addr == 24'h340102, "R4 address", mem_addr, 24'h340102);
    rd(3'd1, v); chk(v == 16'h0013, "R6 overrun and level", v, 16'h0013);
    mem_ready = 1; idle(8);
    wr(3'd1, 16'h0003);
    rd(3'd1, v); chk(v == 16'h0000, "R6 cleared", v, 0);
    // R3 stopped channel ignores bytes
    wr(3'd0, 16'h0000);
    send(8'h55); send(8'h56); idle(2);
    chk(mem_req == 0, "R3 no request", mem_req, 0);
    rd(3'd1, v); chk(v == 16'h0000, "R3 level zero", v, 0);
    // R10 gating by enable
    wr(3'd6, 16'd1);
    wr(3'd0, 16'h0003);
    send(8'h61); idle(2);
    chk(irq_o == 0, "R10 masked", irq_o, 0);
    rd(3'd1, v); chk(v[0] == 1, "R10 flag pending", v, 1);
    wr(3'd0, 16'h000B);
    chk(irq_o == 1, "R10 unmasked", irq_o, 1);
    wr(3'd1, 16'h0001);
    // R8 timeout
    wr(3'd7, 16'd10);
    wr(3'd0, 16'h000D);
    send(8'h71); idle(5);
    chk(irq_o == 0, "R8 before timeout", irq_o, 0);
    idle(10);
    chk(irq_o == 1, "R8 after timeout", irq_o, 1);
    wr(3'd1, 16'h0001); idle(30);
    chk(irq_o == 0, "R8 no repeat", irq_o, 0);
    // R9 silent
    wr(3'd0, 16'h0009);
    for (int i = 0; i < 5; i++) send(8'h80 + 8'(i));
    idle(30);
    chk(irq_o == 0, "R9 silent irq", irq_o, 0);
    rd(3'd1, v); chk(v[0] == 0, "R9 silent flag", v, 0);
    // random phase, checked by the model each cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rx_valid  = ($urandom_range(0, 2) == 0);
      rx_data   = 8'($urandom);
      mem_ready = ($urandom_range(0, 3) != 0);
      reg_addr  = 3'($urandom_range(0, 7));
      reg_wr    = 0;
      if ($urandom_range(0, 15) == 0) begin
        reg_wr = 1;
        case ($urandom_range(0, 3))
          0: begin reg_addr = 3'd0; reg_wdata = {12'd0, 1'b1, 2'($urandom_range(0, 3)), ($urandom_range(0, 7) != 0)}; end
          1: begin reg_addr = 3'd1; reg_wdata = 16'($urandom_range(0, 3)); end
          2: begin reg_addr = 3'd6; reg_wdata = 16'($urandom_range(0, 5)); end
          default: begin reg_addr = 3'd7; reg_wdata = 16'($urandom_range(0, 8)); end
        endcase
      end
    end
    @(negedge clk); rx_valid = 0; reg_wr = 0;
    idle(4);
    summary();
  end
endmodule